// File: doc/BRIEF.md
# Floating-Point Instruction Decoder

This block turns 16-bit floating-point instruction words into a compact decoded form for an execution pipeline. A word is presented with a valid strobe. One clock later the block returns an operation code, the destination and source register fields, a select between the two floating-point system registers (the FPU communication register, called FPUL here, and the status/control register), and a flag for words it does not accept. Executing the operations is left to downstream units.

Decoding works on three nested levels. Words whose top nibble is 0xF are floating-point operations. Their low nibble picks the operation. One value of that nibble opens a single-operand group, which is keyed by the m field (bits 7:4). One m value in that group opens an extended group, which is keyed by the low bits of the n field (bits 11:8). Any other word goes through a separate masked match that recognises the system-register transfer forms.

The block also holds the condition bit. On a compare it loads a comparator result that an external unit supplies alongside the word.

Top module: `fpu_insn_decoder`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, out_valid, out_illegal and out_tbit are 0, out_op is 0 (no operation), and out_rn, out_rm, out_sys_ul and out_const are 0.
- R2: out_valid is 1 in the cycle after each cycle with in_valid high, and 0 otherwise. The payload outputs keep their values while no new word is accepted.
- R3: For a word with bits 15:12 = 0xF, out_rn = bits 11:8 and out_rm = bits 7:4. Function nibble (bits 3:0) values 0 to 5 give codes 1 to 6: add, subtract, multiply, divide, compare-equal, compare-greater. Nibble 0xE gives code 14, multiply-accumulate.
- R4: Function nibble values 6 to 0xC give codes 7 to 13: load indexed, store indexed, load indirect, load post-increment, store indirect, store pre-decrement, register copy. In every case the code is the nibble plus 1.
- R5: Function nibble 0xF is illegal.
- R6: With function nibble 0xD, m values 0 to 0xB give codes 15 to 26, which is 15 plus m. In order these are: copy from FPUL, copy to FPUL, int-to-float, truncate to int, negate, absolute value, square root, reciprocal square root, load zero, load one, single-to-double, double-to-single. m = 0xE gives code 27 (inner product). m = 0xC and 0xD are illegal.
- R7: With function 0xD and m = 0xF, the low bits n[1:0] select the operation. If n[1:0] = 3, n[3:2] values 0, 1 and 2 give the toggle codes 28, 29 and 30 (size, precision, bank), and n[3:2] = 3 gives code 0 without the illegal flag. If n[1:0] = 1, the code is 31 (matrix transform) and out_rn = n - 1. Any other value of n[1:0] gives code 32 (sine/cosine).
- R8: For a word with bits 15:12 other than 0xF, bits 15:12 and 7:0 are compared as a group and bits 11:8 are passed out on out_rn with out_rm = 0. Patterns 0x0_5A and 0x0_6A give code 33 (system register to Rn). Patterns 0x4_5A and 0x4_6A give code 34 (Rn to system register). Patterns 0x4_52 and 0x4_62 give code 35 (pre-decrement store). Patterns 0x4_56 and 0x4_66 give code 36 (load, then post-increment). out_sys_ul is word bit 4, where 1 selects FPUL and 0 selects the status register.
- R9: Every other word outside the 0xF group is illegal.
- R10: An accepted compare-equal or compare-greater word loads cmp_result into out_tbit, visible with the decoded result. Every other word, and every cycle without a word, leaves out_tbit unchanged.
- R11: out_const is 0x3F800000 (1.0 in single precision) for the load-one code and 0 for every other code.
- R12: An illegal word gives out_illegal = 1 for exactly the one cycle in which out_valid is 1, together with code 0, out_rn = out_rm = 0 and out_sys_ul = 0. out_illegal is never 1 while out_valid is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction word strobe |
| in_word | input | 16 | Instruction word |
| cmp_result | input | 1 | Comparator outcome for a compare word |
| out_valid | output | 1 | Decoded result present |
| out_op | output | 6 | Operation code |
| out_rn | output | 4 | Destination register field |
| out_rm | output | 4 | Source register field |
| out_sys_ul | output | 1 | System register select, 1 = FPUL |
| out_illegal | output | 1 | Word not accepted |
| out_tbit | output | 1 | Condition bit |
| out_const | output | 32 | Constant value for the load forms |

## Verification
A wrong branch in any of the three nested levels shows up at out_op or out_illegal on the cycle right after that word, and the masked system path shows up the same way. Because of this, sweeping every function nibble, every m value and every n value catches a misrouted level within one result. A corrupted condition bit lasts until the next compare and is visible on every valid result after it. For that reason the bench predicts out_tbit for every item, not only for compares. Payload registers that are not held steady between words are caught on the idle cycles.

// File: rtl/fpdec_pkg.sv
package fpdec_pkg;

  localparam int OP_W  = 6;
  localparam int FLD_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_NOP      = 6'd0,
    OP_ADD      = 6'd1,
    OP_SUB      = 6'd2,
    OP_MUL      = 6'd3,
    OP_DIV      = 6'd4,
    OP_CMPEQ    = 6'd5,
    OP_CMPGT    = 6'd6,
    OP_LD_IDX   = 6'd7,
    OP_ST_IDX   = 6'd8,
    OP_LD_IND   = 6'd9,
    OP_LD_INC   = 6'd10,
    OP_ST_IND   = 6'd11,
    OP_ST_DEC   = 6'd12,
    OP_MOV_RR   = 6'd13,
    OP_MAC      = 6'd14,
    OP_FROM_UL  = 6'd15,
    OP_TO_UL    = 6'd16,
    OP_FLOAT    = 6'd17,
    OP_TRUNC    = 6'd18,
    OP_NEG      = 6'd19,
    OP_ABS      = 6'd20,
    OP_SQRT     = 6'd21,
    OP_RSQRT    = 6'd22,
    OP_LDZERO   = 6'd23,
    OP_LDONE    = 6'd24,
    OP_S2D      = 6'd25,
    OP_D2S      = 6'd26,
    OP_DOT      = 6'd27,
    OP_TGL_SIZE = 6'd28,
    OP_TGL_PREC = 6'd29,
    OP_TGL_BANK = 6'd30,
    OP_MTX      = 6'd31,
    OP_SINCOS   = 6'd32,
    OP_SYS_RD   = 6'd33,
    OP_SYS_WR   = 6'd34,
    OP_SYS_PUSH = 6'd35,
    OP_SYS_POP  = 6'd36
  } fop_e;

  typedef struct packed {
    fop_e             op;
    logic [FLD_W-1:0] rn;
    logic [FLD_W-1:0] rm;
    logic             sys_ul;
    logic             illegal;
  } fdec_t;

  localparam fdec_t DEC_BAD = '{op: OP_NOP, rn: '0, rm: '0, sys_ul: 1'b0, illegal: 1'b1};

endpackage

// File: rtl/fpdec_one_op.sv
// Single-operand subgroup (keyed by m) and the extended control
// subgroup nested inside it (keyed by the low bits of n).
module fpdec_one_op
  import fpdec_pkg::*;
(
  input  logic [FLD_W-1:0] fld_n,
  input  logic [FLD_W-1:0] fld_m,
  output fdec_t            dec
);

  localparam logic [FLD_W-1:0] M_LAST_PLAIN = 4'hB;
  localparam logic [OP_W-1:0]  ONE_BASE     = OP_W'(OP_FROM_UL);
  localparam logic [OP_W-1:0]  TGL_BASE     = OP_W'(OP_TGL_SIZE);

  fdec_t ext_dec;

  // extended control subgroup
  always_comb begin
    ext_dec = '{op: OP_NOP, rn: fld_n, rm: fld_m, sys_ul: 1'b0, illegal: 1'b0};
    unique case (fld_n[1:0])
      2'd3: begin
        if (fld_n[3:2] != 2'd3) begin
          ext_dec.op = fop_e'(TGL_BASE + {{(OP_W-2){1'b0}}, fld_n[3:2]});
        end
      end
      2'd1: begin
        ext_dec.op = OP_MTX;
        ext_dec.rn = {fld_n[3:2], 2'b00};
      end
      default: ext_dec.op = OP_SINCOS;
    endcase
  end

  // single-operand subgroup
  always_comb begin
    dec = '{op: OP_NOP, rn: fld_n, rm: fld_m, sys_ul: 1'b0, illegal: 1'b0};
    if (fld_m <= M_LAST_PLAIN) begin
      dec.op = fop_e'(ONE_BASE + {{(OP_W-FLD_W){1'b0}}, fld_m});
    end else begin
      unique case (fld_m)
        4'hE:    dec.op = OP_DOT;
        4'hF:    dec = ext_dec;
        default: dec = DEC_BAD;
      endcase
    end
  end

endmodule

// File: rtl/fpdec_two_op.sv
// Top level of the 0xF group: the function nibble selects the operation.
module fpdec_two_op
  import fpdec_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic [WORD_W-1:0] word,
  output fdec_t             dec
);

  localparam int FN_LO = 0;
  localparam int M_LO  = FLD_W;
  localparam int N_LO  = 2 * FLD_W;

  localparam logic [FLD_W-1:0] FN_LAST_DIRECT = 4'hC;

  logic [FLD_W-1:0] fn, fld_m, fld_n;
  fdec_t            one_dec;

  assign fn    = word[FN_LO +: FLD_W];
  assign fld_m = word[M_LO  +: FLD_W];
  assign fld_n = word[N_LO  +: FLD_W];

  fpdec_one_op i_one (
    .fld_n (fld_n),
    .fld_m (fld_m),
    .dec   (one_dec)
  );

  always_comb begin
    dec = '{op: OP_NOP, rn: fld_n, rm: fld_m, sys_ul: 1'b0, illegal: 1'b0};
    if (fn <= FN_LAST_DIRECT) begin
      dec.op = fop_e'({{(OP_W-FLD_W){1'b0}}, fn} + OP_W'(1));
    end else begin
      unique case (fn)
        4'hD:    dec = one_dec;
        4'hE:    dec.op = OP_MAC;
        default: dec = DEC_BAD;
      endcase
    end
  end

endmodule

// File: rtl/fpdec_sys.sv
// Masked match of the system-register transfer forms; n is a field, not a key.
module fpdec_sys
  import fpdec_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic [WORD_W-1:0] word,
  output fdec_t             dec
);

  localparam int N_LO  = 2 * FLD_W;
  localparam int SEL_B = FLD_W;
  localparam int KEY_W = 3 * FLD_W;

  logic [KEY_W-1:0] key;

  assign key = {word[WORD_W-1 -: FLD_W], word[2*FLD_W-1:0]};

  always_comb begin
    dec = '{op: OP_NOP, rn: word[N_LO +: FLD_W], rm: '0,
            sys_ul: word[SEL_B], illegal: 1'b0};
    unique case (key)
      12'h05A, 12'h06A: dec.op = OP_SYS_RD;
      12'h45A, 12'h46A: dec.op = OP_SYS_WR;
      12'h452, 12'h462: dec.op = OP_SYS_PUSH;
      12'h456, 12'h466: dec.op = OP_SYS_POP;
      default:          dec = DEC_BAD;
    endcase
  end

endmodule

// File: rtl/fpu_insn_decoder.sv
module fpu_insn_decoder
  import fpdec_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [15:0]       in_word,
  input  logic              cmp_result,
  output logic              out_valid,
  output logic [5:0]        out_op,
  output logic [3:0]        out_rn,
  output logic [3:0]        out_rm,
  output logic              out_sys_ul,
  output logic              out_illegal,
  output logic              out_tbit,
  output logic [31:0]       out_const
);

  localparam int              DATA_W   = 1 + EXP_W + FRAC_W;
  localparam int              EXP_BIAS = (1 << (EXP_W - 1)) - 1;
  localparam logic [DATA_W-1:0] ONE_BITS = DATA_W'(EXP_BIAS) << FRAC_W;
  localparam logic [FLD_W-1:0]  FP_CLASS = '1;

  logic [WORD_W-1:0] word;
  fdec_t             fp_dec, sys_dec, sel_dec;

  assign word = WORD_W'(in_word);

  fpdec_two_op #(.WORD_W(WORD_W)) i_two (
    .word (word),
    .dec  (fp_dec)
  );

  fpdec_sys #(.WORD_W(WORD_W)) i_sys (
    .word (word),
    .dec  (sys_dec)
  );

  assign sel_dec = (word[WORD_W-1 -: FLD_W] == FP_CLASS) ? fp_dec : sys_dec;

  // next state
  logic              valid_d, ill_d, t_d, pay_en;
  fdec_t             pay_d;
  logic [DATA_W-1:0] const_d;

  always_comb begin
    valid_d = in_valid;
    ill_d   = in_valid & sel_dec.illegal;
    pay_en  = in_valid;
    pay_d   = sel_dec;
    const_d = (sel_dec.op == OP_LDONE) ? ONE_BITS : '0;
    t_d     = out_tbit;
    if (in_valid && (sel_dec.op == OP_CMPEQ || sel_dec.op == OP_CMPGT)) begin
      t_d = cmp_result;
    end
  end

  // registers
  logic              valid_q, ill_q, t_q;
  fdec_t             pay_q;
  logic [DATA_W-1:0] const_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      ill_q   <= 1'b0;
      t_q     <= 1'b0;
    end else begin
      valid_q <= valid_d;
      ill_q   <= ill_d;
      t_q     <= t_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pay_q   <= '{op: OP_NOP, rn: '0, rm: '0, sys_ul: 1'b0, illegal: 1'b0};
      const_q <= '0;
    end else if (pay_en) begin
      pay_q   <= pay_d;
      const_q <= const_d;
    end
  end

  assign out_valid   = valid_q;
  assign out_illegal = ill_q;
  assign out_tbit    = t_q;
  assign out_op      = 6'(pay_q.op);
  assign out_rn      = pay_q.rn;
  assign out_rm      = pay_q.rm;
  assign out_sys_ul  = pay_q.sys_ul;
  assign out_const   = 32'(const_q);

endmodule

// File: rtl/fpdec_chk.sv
module fpdec_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [15:0] in_word,
  input logic        cmp_result,
  input logic        out_valid,
  input logic [5:0]  out_op,
  input logic [3:0]  out_rn,
  input logic [3:0]  out_rm,
  input logic        out_sys_ul,
  input logic        out_illegal,
  input logic        out_tbit,
  input logic [31:0] out_const
);

  logic is_cmp, is_fp;
  assign is_fp  = in_word[15:12] == 4'hF;
  assign is_cmp = in_valid && is_fp && (in_word[3:0] == 4'h4 || in_word[3:0] == 4'h5);

  p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_valid_drops_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  p_hold_payload_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && out_valid) |=> $stable(out_op) && $stable(out_rn) && $stable(out_rm));

  p_fn_f_illegal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_fp && in_word[3:0] == 4'hF) |=> out_illegal);

  p_tbit_loads_r10: assert property (@(posedge clk) disable iff (!rst_n)
    is_cmp |=> out_tbit == $past(cmp_result));

  p_tbit_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !is_cmp |=> $stable(out_tbit));

  p_one_const_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_op == 6'd24) |-> out_const == 32'h3F80_0000);

  p_sel_only_sys_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_sys_ul) |-> (out_op >= 6'd33 && out_op <= 6'd36));

  p_illegal_shape_r12: assert property (@(posedge clk) disable iff (!rst_n)
    out_illegal |-> out_valid && out_op == 6'd0 && out_rn == 4'd0 && out_rm == 4'd0);

endmodule

bind fpu_insn_decoder fpdec_chk i_fpdec_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_word     (in_word),
  .cmp_result  (cmp_result),
  .out_valid   (out_valid),
  .out_op      (out_op),
  .out_rn      (out_rn),
  .out_rm      (out_rm),
  .out_sys_ul  (out_sys_ul),
  .out_illegal (out_illegal),
  .out_tbit    (out_tbit),
  .out_const   (out_const)
);

// File: tb/test_fpu_insn_decoder.sv
module test_fpu_insn_decoder;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_word = '0;
  logic        cmp_result = 1'b0;
  logic        out_valid, out_sys_ul, out_illegal, out_tbit;
  logic [5:0]  out_op;
  logic [3:0]  out_rn, out_rm;
  logic [31:0] out_const;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpu_insn_decoder i_fpu_insn_decoder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
    .cmp_result(cmp_result), .out_valid(out_valid), .out_op(out_op),
    .out_rn(out_rn), .out_rm(out_rm), .out_sys_ul(out_sys_ul),
    .out_illegal(out_illegal), .out_tbit(out_tbit), .out_const(out_const)
  );

  typedef struct packed {
    logic [5:0]  op;
    logic [3:0]  rn;
    logic [3:0]  rm;
    logic        ul;
    logic        ill;
    logic        t;
    logic [31:0] k;
  } exp_t;

  exp_t        exp_q[$];
  string       tag_q[$];
  logic [15:0] word_q[$];
  int          checks = 0;
  int          failures = 0;
  logic        model_t = 1'b0;
  logic [5:0]  last_op = '0;
  logic        done = 1'b0;

  function automatic exp_t model(input logic [15:0] w, input logic c, input logic t_in);
    exp_t       e;
    logic [3:0] n, m, f;
    logic [11:0] key;
    logic        bad;
    n = w[11:8]; m = w[7:4]; f = w[3:0];
    e = '0; e.t = t_in; bad = 1'b0;
    if (w[15:12] == 4'hF) begin
      e.rn = n; e.rm = m;
      if (f <= 4'hC) begin
        e.op = 6'(f) + 6'd1;
        if (f == 4'h4 || f == 4'h5) e.t = c;
      end else if (f == 4'hE) e.op = 6'd14;
      else if (f == 4'hF) bad = 1'b1;
      else if (m <= 4'hB) e.op = 6'd15 + 6'(m);
      else if (m == 4'hC || m == 4'hD) bad = 1'b1;
      else if (m == 4'hE) e.op = 6'd27;
      else if (n[1:0] == 2'd3) e.op = (n[3:2] == 2'd3) ? 6'd0 : 6'd28 + 6'(n[3:2]);
      else if (n[1:0] == 2'd1) begin e.op = 6'd31; e.rn = n - 4'd1; end
      else e.op = 6'd32;
    end else begin
      key = {w[15:12], w[7:0]};
      e.rn = n; e.ul = w[4];
      if (key == 12'h05A || key == 12'h06A) e.op = 6'd33;
      else if (key == 12'h45A || key == 12'h46A) e.op = 6'd34;
      else if (key == 12'h452 || key == 12'h462) e.op = 6'd35;
      else if (key == 12'h456 || key == 12'h466) e.op = 6'd36;
      else bad = 1'b1;
    end
    if (bad) begin e.op = '0; e.rn = '0; e.rm = '0; e.ul = 1'b0; e.ill = 1'b1; end
    e.k = (e.op == 6'd24) ? 32'h3F80_0000 : 32'h0;
    return e;
  endfunction

  function automatic string tag_of(input logic [15:0] w, input exp_t e);
    string s;
    if (w[15:12] != 4'hF) s = e.ill ? "R9" : "R8";
    else if (w[3:0] <= 4'h5) s = (w[3:0] >= 4'h4) ? "R3 R10" : "R3";
    else if (w[3:0] <= 4'hC) s = "R4";
    else if (w[3:0] == 4'hE) s = "R3";
    else if (w[3:0] == 4'hF) s = "R5";
    else if (w[7:4] == 4'hF) s = "R7";
    else s = (w[7:4] == 4'h9) ? "R6 R11" : "R6";
    if (e.ill) s = {s, " R12"};
    return s;
  endfunction

  task automatic send(input logic [15:0] w, input logic c);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1; in_word = w; cmp_result = c;
    e = model(w, c, model_t);
    model_t = e.t;
    exp_q.push_back(e);
    tag_q.push_back(tag_of(w, e));
    word_q.push_back(w);
  endtask

  task automatic idle(input int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      in_valid = 1'b0; in_word = 16'hFFFF; cmp_result = ~cmp_result;
    end
  endtask

  task automatic check(input bit ok, input string req, input string msg);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s", req, msg);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (out_valid) begin
        exp_t        e;
        exp_t        got;
        string       tg;
        logic [15:0] w;
        if (exp_q.size() == 0) begin
          check(1'b0, "R2", "unexpected out_valid with empty queue");
        end else begin
          e = exp_q.pop_front(); tg = tag_q.pop_front(); w = word_q.pop_front();
          got = '{op: out_op, rn: out_rn, rm: out_rm, ul: out_sys_ul,
                  ill: out_illegal, t: out_tbit, k: out_const};
          check(got == e, tg, $sformatf(
            "word=%h got op=%0d rn=%0d rm=%0d ul=%0b ill=%0b t=%0b k=%h exp op=%0d rn=%0d rm=%0d ul=%0b ill=%0b t=%0b k=%h",
            w, got.op, got.rn, got.rm, got.ul, got.ill, got.t, got.k,
            e.op, e.rn, e.rm, e.ul, e.ill, e.t, e.k));
          last_op = out_op;
        end
      end else if (checks > 0) begin
        check(out_illegal == 1'b0 && out_op == last_op && out_tbit == model_t, "R2 R12",
              $sformatf("idle got ill=%0b op=%0d t=%0b exp ill=0 op=%0d t=%0b",
                        out_illegal, out_op, out_tbit, last_op, model_t));
      end
    end
  end

  task automatic reset_check();
    @(negedge clk);
    check(out_valid == 0 && out_illegal == 0 && out_tbit == 0 && out_op == 0 &&
          out_rn == 0 && out_rm == 0 && out_sys_ul == 0 && out_const == 0, "R1",
          $sformatf("got v=%0b ill=%0b t=%0b op=%0d rn=%0d rm=%0d ul=%0b k=%h exp all 0",
                    out_valid, out_illegal, out_tbit, out_op, out_rn, out_rm, out_sys_ul, out_const));
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog expired, got running expected finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : driver
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    reset_check();                                     // R1 during reset
    rst_n = 1'b1;
    reset_check();                                     // R1 after release
    // R3 R4 R5 R10: every function nibble, compares with both outcomes
    for (int f = 0; f < 16; f++) send({4'hF, 4'h3, 4'h5, 4'(f)}, f[0]);
    send(16'hF124, 1'b1);
    send(16'hF985, 1'b0);
    idle(2);
    // R6 R11: every m in the single-operand group
    for (int m = 0; m < 16; m++) send({4'hF, 4'h6, 4'(m), 4'hD}, 1'b1);
    idle(1);
    // R7: every n in the extended group
    for (int n = 0; n < 16; n++) send({4'hF, 4'(n), 4'hF, 4'hD}, 1'b0);
    idle(3);
    // R8 R9: system transfer forms, n varied, and near-miss patterns
    for (int n = 0; n < 16; n += 5) begin
      send({4'h0, 4'(n), 8'h5A}, 1'b1); send({4'h0, 4'(n), 8'h6A}, 1'b0);
      send({4'h4, 4'(n), 8'h5A}, 1'b1); send({4'h4, 4'(n), 8'h6A}, 1'b0);
      send({4'h4, 4'(n), 8'h52}, 1'b1); send({4'h4, 4'(n), 8'h62}, 1'b0);
      send({4'h4, 4'(n), 8'h56}, 1'b1); send({4'h4, 4'(n), 8'h66}, 1'b0);
    end
    send(16'h0052, 1'b1); send(16'h405B, 1'b0); send(16'h8056, 1'b1);
    send(16'h007A, 1'b0); send(16'h4A4A, 1'b1); send(16'h0000, 1'b0);
    idle(2);
    // mixed pseudo-random stream with occasional gaps
    lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      send(lfsr, lfsr[7]);
      if (lfsr[2:0] == 3'd0) idle(1);
    end
    idle(3);
    // R1: reset in the middle of a run clears the condition bit
    send(16'hF004, 1'b1);
    idle(2);
    rst_n = 1'b0; model_t = 1'b0; last_op = '0;
    reset_check();
    @(negedge clk); rst_n = 1'b1;
    checks = checks;
    reset_check();
    send(16'hF00D, 1'b1);
    idle(3);
    check(exp_q.size() == 0, "R2", $sformatf("pending results got %0d exp 0", exp_q.size()));
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule